// File: doc/BRIEF.md
# Write-Enable Latch and Block-Protect Guard

This block sits behind the command decoder of a serial nonvolatile memory. It holds the write-enable latch and the persistent protect bits, and it builds the 8-bit status byte. The decoder signals each command as a one-cycle strobe with an opcode and, for array writes, the start address. It also marks every complete data byte received. The block follows the chip-select line, a frame being everything between its falling and rising edge. It decides on the rising edge whether that frame's write may start.

A granted write is reported as a one-cycle pulse. The busy flag stays raised until the storage engine reports completion with a done pulse. Completion also clears the latch and, for a status write, loads the new protect bits. The protect bits are ordinary flops that a soft reset leaves alone. Only their value at power-up comes from a parameter.

Top module: `wp_guard`

## Requirements
- R1: `status_o` is `{4'b1111, bp[1], bp[0], latch, busy}`: bit 0 busy, bit 1 write-enable latch, bits 3:2 the protect field, bits 7:4 always one. After reset with the default protect value 00 it reads 0xF0.
- R2: Only an enable command (opcode 1) sets the latch, and only on the clock edge that sees chip select high after the frame that carried it. A disable command (opcode 2) clears the latch on the clock edge that samples its strobe.
- R3: An array write (opcode 3) in the same frame as the enable command is refused, because the latch is still clear when that frame ends.
- R4: While the protect pin `wp_n` is low, the latch is cleared on the next clock edge and stays clear, enable commands are lost, and no write is granted.
- R5: A status write (opcode 4) changes only bits 3:2 of the status byte, taking them from bits 3:2 of the last data byte of the frame. The new value appears on the clock edge that samples the done pulse of that write.
- R6: For a 9-bit address, protect field 00 fences nothing, 01 fences 0x180–0x1FF, 10 fences 0x100–0x1FF and 11 fences the whole array. An array write whose start address is fenced is refused. Status writes are not fenced.
- R7: `grant_o` pulses for exactly one cycle, on the clock edge that first sees `cs_n` high after a frame. It pulses only if the frame carried a write command and at least one complete data byte, the latch is set, `wp_n` is high and busy is clear. A write frame with no complete data byte is dropped.
- R8: Busy rises on the same edge as `grant_o`. The done pulse clears busy and the latch on the clock edge that samples it.
- R9: While busy is set, enable, disable and write commands have no effect on the latch or on grants.
- R10: A synchronous reset clears the latch, busy and any frame in progress, and keeps the protect bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high soft reset |
| cs_n | input | 1 | Chip select, low while a frame is open |
| wp_n | input | 1 | Write-protect pin, low inhibits writes |
| cmd_stb | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 3 | Opcode: 1 enable, 2 disable, 3 array write, 4 status write |
| cmd_addr | input | ADDR_W | Start address of an array write |
| byte_stb | input | 1 | One-cycle strobe for a complete data byte |
| byte_data | input | 8 | Data byte value |
| cycle_done | input | 1 | End of the internal write cycle |
| grant_o | output | 1 | Write may start, one-cycle pulse |
| status_o | output | 8 | Status byte for readout |

## Verification
A stuck or early latch shows up in bit 1 of the status byte within one cycle of the frame end. It also shows up in the next write frame, which would be wrongly granted or refused. A wrong protect field or fence decode leaves a wrong value in bits 3:2 after the next done pulse. It also gives an unexpected grant on the first write near a quarter boundary. A busy flag that does not block commands lets a disable frame during a write change bit 1 at once. Each of these shows at the next sample after the frame or done pulse.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_WRITE = 3'd3,
    OP_WRSR  = 3'd4
  } wg_op_e;

  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_ARRAY  = 2'd1,
    FK_STATUS = 2'd2
  } wg_kind_e;
endpackage

// File: rtl/wg_frame.sv
module wg_frame
  import wg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              busy,
  input  logic              cmd_stb,
  input  wg_op_e            cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_stb,
  input  logic [1:0]        byte_bits,
  output logic              frame_end,
  output logic              wrdi_evt,
  output wg_kind_e          kind,
  output logic              has_data,
  output logic              en_req,
  output logic [ADDR_W-1:0] waddr,
  output logic [1:0]        sbits
);
  logic     cs_q;
  logic     accept;
  wg_kind_e kind_q;
  logic     has_q, en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0] sbits_q;

  assign frame_end = cs_n & ~cs_q;
  assign accept    = ~cs_n & ~busy;
  assign wrdi_evt  = accept & cmd_stb & (cmd_op == OP_WRDI);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b1;
      kind_q  <= FK_NONE;
      has_q   <= 1'b0;
      en_q    <= 1'b0;
      addr_q  <= '0;
      sbits_q <= '0;
    end else begin
      cs_q <= cs_n;
      if (frame_end) begin
        kind_q <= FK_NONE;
        has_q  <= 1'b0;
        en_q   <= 1'b0;
      end else if (accept) begin
        if (cmd_stb) begin
          case (cmd_op)
            OP_WREN:  en_q <= 1'b1;
            OP_WRDI:  en_q <= 1'b0;
            OP_WRITE: begin
              kind_q <= FK_ARRAY;
              addr_q <= cmd_addr;
              has_q  <= 1'b0;
            end
            OP_WRSR: begin
              kind_q <= FK_STATUS;
              has_q  <= 1'b0;
            end
            default: ;
          endcase
        end else if (byte_stb && kind_q != FK_NONE) begin
          has_q   <= 1'b1;
          sbits_q <= byte_bits;
        end
      end
    end
  end

  assign kind     = kind_q;
  assign has_data = has_q;
  assign en_req   = en_q;
  assign waddr    = addr_q;
  assign sbits    = sbits_q;

  // R9: a frame's contents are frozen while a write cycle runs
  a_r9_busy_freezes_frame: assert property (@(posedge clk) disable iff (rst)
    busy && !frame_end |=> $stable(kind_q) && $stable(en_q) && $stable(has_q));
endmodule

// File: rtl/wg_fence.sv
module wg_fence #(
  parameter int ADDR_W = 9
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP_W = 2;
  logic [TOP_W-1:0] top_bits;

  generate
    if (ADDR_W >= TOP_W) begin : g_wide
      assign top_bits = addr[ADDR_W-1 -: TOP_W];
    end else begin : g_narrow
      assign top_bits = {addr[ADDR_W-1], addr[ADDR_W-1]};
    end
  endgenerate

  always_comb begin
    case (bp)
      2'b01:   hit = (top_bits == 2'b11);
      2'b10:   hit = top_bits[TOP_W-1];
      2'b11:   hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/wg_state.sv
module wg_state
  import wg_pkg::*;
#(
  parameter logic [1:0] BP_INIT = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wp_n,
  input  logic       frame_end,
  input  logic       wrdi_evt,
  input  wg_kind_e   kind,
  input  logic       has_data,
  input  logic       en_req,
  input  logic [1:0] sbits,
  input  logic       fence_hit,
  input  logic       cycle_done,
  output logic       wel,
  output logic       busy,
  output logic [1:0] bp,
  output logic       grant
);
  logic       wel_q, busy_q, grant_q, sts_pend_q;
  logic [1:0] bp_next_q;
  logic [1:0] bp_q = BP_INIT;
  logic       may_write, grant_d, finish;

  assign may_write = wel_q & wp_n & ~busy_q & has_data;
  assign grant_d   = frame_end & may_write &
                     ((kind == FK_ARRAY && !fence_hit) || kind == FK_STATUS);
  assign finish    = cycle_done & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q      <= 1'b0;
      busy_q     <= 1'b0;
      grant_q    <= 1'b0;
      sts_pend_q <= 1'b0;
      bp_next_q  <= '0;
    end else begin
      grant_q <= grant_d;
      if (grant_d) begin
        busy_q     <= 1'b1;
        sts_pend_q <= (kind == FK_STATUS);
        bp_next_q  <= sbits;
      end else if (finish) begin
        busy_q     <= 1'b0;
        sts_pend_q <= 1'b0;
      end
      if (!wp_n)                                wel_q <= 1'b0;
      else if (finish)                          wel_q <= 1'b0;
      else if (wrdi_evt)                        wel_q <= 1'b0;
      else if (frame_end && en_req && !busy_q)  wel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && finish && sts_pend_q) bp_q <= bp_next_q;
  end

  assign wel   = wel_q;
  assign busy  = busy_q;
  assign bp    = bp_q;
  assign grant = grant_q;

  // R4: protect pin low empties the latch by the next edge
  a_r4_wp_clears_latch: assert property (@(posedge clk) disable iff (rst)
    !wp_n |=> !wel_q);
  // R8: done pulse ends busy and drops the latch
  a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
    cycle_done && busy_q |=> !busy_q && !wel_q);
  // R2: latch only rises at a frame end
  a_r2_latch_rises_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    $rose(wel_q) |-> $past(frame_end) && $past(en_req));
  // R7: a grant needs the latch and the pin high one edge before
  a_r7_grant_needs_latch: assert property (@(posedge clk) disable iff (rst)
    grant_q |-> $past(wel_q) && $past(wp_n) && !$past(busy_q));
  // R5: protect bits move only at completion of a status write
  a_r5_bp_moves_at_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp_q) |-> $past(cycle_done) && $past(busy_q));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wg_pkg::*;
#(
  parameter int         ADDR_W  = 9,
  parameter logic [1:0] BP_INIT = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cmd_stb,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              cycle_done,
  output logic              grant_o,
  output logic [7:0]        status_o
);
  localparam logic [3:0] HIGH_ONES = 4'hF;

  logic              frame_end, wrdi_evt, has_data, en_req, fence_hit;
  logic              wel, busy, grant;
  wg_kind_e          kind;
  logic [ADDR_W-1:0] waddr;
  logic [1:0]        sbits, bp;
  logic              unused_bits;

  assign unused_bits = ^{byte_data[7:4], byte_data[1:0]};

  wg_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst(rst), .cs_n(cs_n), .busy(busy),
    .cmd_stb(cmd_stb), .cmd_op(wg_op_e'(cmd_op)), .cmd_addr(cmd_addr),
    .byte_stb(byte_stb), .byte_bits(byte_data[3:2]),
    .frame_end(frame_end), .wrdi_evt(wrdi_evt), .kind(kind),
    .has_data(has_data), .en_req(en_req), .waddr(waddr), .sbits(sbits)
  );

  wg_fence #(.ADDR_W(ADDR_W)) u_fence (
    .bp(bp), .addr(waddr), .hit(fence_hit)
  );

  wg_state #(.BP_INIT(BP_INIT)) u_state (
    .clk(clk), .rst(rst), .wp_n(wp_n), .frame_end(frame_end),
    .wrdi_evt(wrdi_evt), .kind(kind), .has_data(has_data), .en_req(en_req),
    .sbits(sbits), .fence_hit(fence_hit), .cycle_done(cycle_done),
    .wel(wel), .busy(busy), .bp(bp), .grant(grant)
  );

  assign grant_o  = grant;
  assign status_o = {HIGH_ONES, bp, wel, busy};

  // R6: a fenced array write is never granted
  a_r6_fenced_no_grant: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> !($past(fence_hit) && $past(kind) == FK_ARRAY));
  // R7: grant follows a chip-select rise seen on the previous edge
  a_r7_grant_after_cs_rise: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> $past(cs_n) && !$past(cs_n, 2));
  // R7: grant is a single-cycle pulse
  a_r7_grant_one_cycle: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> !grant_o);
endmodule

// File: tb/test_wp_guard.sv
module test_wp_guard;
  localparam int AW = 9;
  localparam logic [2:0] N = 3'd0, EN = 3'd1, DIS = 3'd2, WR = 3'd3, SR = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wp_n = 1'b1, cmd_stb = 1'b0, byte_stb = 1'b0, cycle_done = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] byte_data = 8'h00;
  logic grant_o;
  logic [7:0] status_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  typedef struct { logic g; logic [7:0] s; string tag; } item_t;
  item_t sb_q[$];
  event sample_ev;

  always #10 clk = ~clk;

  wp_guard #(.ADDR_W(AW)) i_wp_guard (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n), .cmd_stb(cmd_stb),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .byte_stb(byte_stb),
    .byte_data(byte_data), .cycle_done(cycle_done),
    .grant_o(grant_o), .status_o(status_o)
  );

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (grant_o !== it.g || status_o !== it.s) begin
          n_bad++;
          $display("FAIL %s: grant=%0b status=%02h expected grant=%0b status=%02h",
                   it.tag, grant_o, status_o, it.g, it.s);
        end
      end
    end
  end

  task automatic expect_now(input logic g, input logic [7:0] s, input string tag);
    item_t it;
    it.g = g; it.s = s; it.tag = tag;
    sb_q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  task automatic send_op(input logic [2:0] op, input logic [AW-1:0] a);
    if (op != N) begin
      @(negedge clk); cmd_stb = 1'b1; cmd_op = op; cmd_addr = a;
      @(negedge clk); cmd_stb = 1'b0;
    end
  endtask

  task automatic frame(input logic [2:0] op1, input logic [2:0] op2,
                       input logic [AW-1:0] a, input int nb, input logic [7:0] d,
                       input logic eg, input logic [7:0] es, input string tag);
    @(negedge clk); cs_n = 1'b0;
    send_op(op1, a);
    send_op(op2, a);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); byte_stb = 1'b1; byte_data = d;
      @(negedge clk); byte_stb = 1'b0;
    end
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    expect_now(eg, es, tag);
  endtask

  task automatic finish_cycle(input logic [7:0] es, input string tag);
    @(negedge clk); cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0;
    expect_now(1'b0, es, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_now(1'b0, 8'hF0, "R1 reset value");

    frame(WR, N, 9'h000, 1, 8'h55, 1'b0, 8'hF0, "R7 write without latch");
    frame(EN, WR, 9'h000, 1, 8'h55, 1'b0, 8'hF2, "R3 enable and write in one frame");
    frame(WR, N, 9'h010, 0, 8'h00, 1'b0, 8'hF2, "R7 write with no data byte");
    frame(WR, N, 9'h020, 2, 8'hA5, 1'b1, 8'hF3, "R8 granted write sets busy");
    frame(DIS, N, 9'h000, 0, 8'h00, 1'b0, 8'hF3, "R9 disable ignored while busy");
    frame(WR, N, 9'h030, 1, 8'h11, 1'b0, 8'hF3, "R9 write ignored while busy");
    finish_cycle(8'hF0, "R8 done clears busy and latch");

    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hF2, "R2 enable at frame end");
    frame(DIS, N, 9'h000, 0, 8'h00, 1'b0, 8'hF0, "R2 disable clears latch");

    wp_n = 1'b0;
    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hF0, "R4 enable lost with pin low");
    wp_n = 1'b1;
    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hF2, "R2 enable with pin high");
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk);
    expect_now(1'b0, 8'hF0, "R4 pin low clears latch");
    frame(WR, N, 9'h040, 1, 8'h00, 1'b0, 8'hF0, "R4 write blocked with pin low");
    wp_n = 1'b1;

    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hF2, "R2 enable");
    frame(SR, N, 9'h000, 1, 8'hF7, 1'b1, 8'hF3, "R5 status write granted, bits not yet moved");
    finish_cycle(8'hF4, "R5 only bits 3:2 taken, BP=01");

    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hF6, "R2 enable");
    frame(WR, N, 9'h180, 1, 8'h00, 1'b0, 8'hF6, "R6 BP=01 fences 0x180");
    frame(WR, N, 9'h17F, 1, 8'h00, 1'b1, 8'hF7, "R6 BP=01 leaves 0x17F open");
    finish_cycle(8'hF4, "R8 done");

    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hF6, "R2 enable");
    frame(SR, N, 9'h000, 2, 8'h08, 1'b1, 8'hF7, "R5 status write BP=10");
    finish_cycle(8'hF8, "R5 BP=10 loaded");
    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hFA, "R2 enable");
    frame(WR, N, 9'h100, 1, 8'h00, 1'b0, 8'hFA, "R6 BP=10 fences 0x100");
    frame(WR, N, 9'h0FF, 1, 8'h00, 1'b1, 8'hFB, "R6 BP=10 leaves 0x0FF open");
    finish_cycle(8'hF8, "R8 done");

    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hFA, "R2 enable before reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    expect_now(1'b0, 8'hF8, "R10 reset keeps BP, clears latch");
    rst = 1'b0;

    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hFA, "R2 enable");
    frame(SR, N, 9'h000, 1, 8'h0C, 1'b1, 8'hFB, "R5 status write BP=11");
    finish_cycle(8'hFC, "R5 BP=11 loaded");
    frame(EN, N, 9'h000, 0, 8'h00, 1'b0, 8'hFE, "R2 enable");
    frame(WR, N, 9'h000, 1, 8'h00, 1'b0, 8'hFE, "R6 BP=11 fences 0x000");
    frame(SR, N, 9'h000, 1, 8'hF3, 1'b1, 8'hFF, "R6 status write not fenced");
    finish_cycle(8'hF0, "R5 BP back to 00");

    repeat (2) @(negedge clk);
    finished = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule